// File: doc/BRIEF.md
# Unaligned Watch Region Decomposer

This block turns a watch request, given as a start address and a byte length, into a series of naturally aligned pieces. Each piece can be covered by one hardware watch slot. The request's address may be unaligned, and its length may be longer than one slot can cover. At each step the piece size comes from a small lookup. The lookup is indexed by the remaining length and by the address offset within the largest slot size. After each piece, the address advances and the remaining length shrinks by the same amount, until nothing is left.

The block has three kinds of request. A count request only walks the sequence and reports how many pieces are needed. It also reports whether that number fits in the slot budget. An insert or remove request hands the pieces, one per cycle, to a downstream slot allocator over a valid/ready handshake. It stops at the first piece the allocator rejects. In every case a one-cycle `done` pulse carries the final status. A request that is already aligned and has a natural length skips the lookup and leaves as a single piece.

Top module: `wp_region_splitter`

## Requirements
- R1: After reset, `req_ready` is 1, `chunk_valid` is 0 and `done` is 0.
- R2: Every piece has a size of 1, 2 or 4 bytes, or also 8 bytes when `WIDE` is 1. Its address is a multiple of its size.
- R3: The size of each piece is the largest allowed size that is no larger than the remaining length and that divides the current address. This matches the lookup: length index = min(remaining, max) - 1, and alignment = address mod max.
- R4: The pieces are contiguous. The first starts at the request address, each next one starts where the previous one ended, and together they cover exactly the requested length.
- R5: With `req_op` 0 or 3 (count), no piece is presented. `done_count` gives the number of pieces, and `done_fits` is 1 exactly when that number is at most `NUM_SLOTS` (4).
- R6: With `req_op` 1 (insert), `chunk_remove` is 0. With `req_op` 2 (remove), `chunk_remove` is 1.
- R7: A piece taken with `chunk_ok` = 0 ends the request. The next cycle shows `done` with `done_fail` = 1, no further piece is presented, and `done_count` is the number of pieces taken before it. If no piece is rejected, `done_fail` is 0 and `done_count` is the full piece count.
- R8: A request of length 1, 2, 4, or 8 when `WIDE` is 1, whose address is a multiple of that length, produces exactly one piece of that length.
- R9: A zero-length request produces `done` in the next cycle, with `done_count` 0 and `done_fail` 0, and presents no piece.
- R10: While `chunk_valid` is 1 and `chunk_ready` is 0, the piece fields hold steady. `req_ready` is 0 from the cycle after a nonzero-length request is taken until that request ends.
- R11: `done` is a one-cycle pulse. A count request needing N pieces raises `done` N cycles after the request is taken, one piece per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request taken when both are high |
| req_op | input | 2 | 0/3 count, 1 insert, 2 remove |
| req_addr | input | ADDR_W | Region start address |
| req_len | input | LEN_W | Region length in bytes |
| chunk_valid | output | 1 | Piece presented to the allocator |
| chunk_ready | input | 1 | Allocator takes the piece |
| chunk_ok | input | 1 | Allocator verdict for the piece being taken |
| chunk_remove | output | 1 | 1 for remove, 0 for insert |
| chunk_addr | output | ADDR_W | Piece start address |
| chunk_size | output | 4 | Piece size in bytes (1, 2, 4 or 8) |
| done | output | 1 | One-cycle end-of-request pulse |
| done_fail | output | 1 | Last request aborted by a rejection |
| done_count | output | LEN_W+1 | Pieces counted or accepted |
| done_fits | output | 1 | done_count is at most NUM_SLOTS |

## Verification
The bench goes after several corner cases, each with the failure it would expose.
- Odd start addresses followed by long runs: a wrong lookup row would emit a piece that is misaligned or too large.
- Lengths of exactly 3, 5, 7 and 8 bytes at every offset: these catch an index that is not capped, or a wide row wrongly used in the narrow variant. Either would change the piece count and make `done_fits` wrong at the four-slot boundary.
- Rejections on the first, a middle and the last piece: a design that kept going after a rejection, or that counted the rejected piece, would report the wrong count or present extra pieces.
- Zero-length requests and aligned natural lengths: these show a missing or off-by-one `done`, and a bypass that splits a piece it should have kept whole.

// File: rtl/wp_split_pkg.sv
package wp_split_pkg;

   typedef enum logic [1:0] {
      OP_COUNT     = 2'd0,
      OP_INSERT    = 2'd1,
      OP_REMOVE    = 2'd2,
      OP_COUNT_ALT = 2'd3
   } wp_op_e;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } wp_state_e;

   function automatic logic op_is_count(input wp_op_e op);
      return (op == OP_COUNT) || (op == OP_COUNT_ALT);
   endfunction

endpackage

// File: rtl/wp_size_lut.sv
module wp_size_lut #(
   parameter int LEN_W = 8,
   parameter bit WIDE  = 1'b0
) (
   input  logic [2:0]       addr_lo,
   input  logic [LEN_W-1:0] rem_len,
   output logic [3:0]       size
);
   localparam int MAXB = WIDE ? 8 : 4;

   logic [2:0] align;
   logic [2:0] idx;

   generate
      if (WIDE) begin : g_wide_align
         assign align = addr_lo;
      end else begin : g_narrow_align
         assign align = {1'b0, addr_lo[1:0]};
      end
   endgenerate

   always_comb begin
      if (rem_len >= LEN_W'(MAXB)) idx = 3'(MAXB - 1);
      else                         idx = 3'(rem_len - LEN_W'(1));
   end

   always_comb begin
      unique case (idx)
         3'd0:       size = 4'd1;
         3'd1, 3'd2: size = align[0] ? 4'd1 : 4'd2;
         3'd7:       size = (align == 3'd0) ? 4'd8 :
                            align[0] ? 4'd1 : (align[1] ? 4'd2 : 4'd4);
         default:    size = align[0] ? 4'd1 : (align[1] ? 4'd2 : 4'd4);
      endcase
   end
endmodule

// File: rtl/wp_bypass_chk.sv
module wp_bypass_chk #(
   parameter int LEN_W = 8,
   parameter bit WIDE  = 1'b0
) (
   input  logic [2:0]       addr_lo,
   input  logic [LEN_W-1:0] len,
   output logic             hit,
   output logic [3:0]       size
);
   logic hit8;

   generate
      if (WIDE) begin : g_has8
         assign hit8 = (len == LEN_W'(8)) && (addr_lo == 3'd0);
      end else begin : g_no8
         assign hit8 = 1'b0;
      end
   endgenerate

   assign hit  = (len == LEN_W'(1))
              || ((len == LEN_W'(2)) && (addr_lo[0] == 1'b0))
              || ((len == LEN_W'(4)) && (addr_lo[1:0] == 2'd0))
              || hit8;
   assign size = len[3:0];
endmodule

// File: rtl/wp_region_splitter.sv
module wp_region_splitter
   import wp_split_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int LEN_W     = 8,
   parameter bit WIDE      = 1'b0,
   parameter int NUM_SLOTS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [1:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [LEN_W-1:0]  req_len,
   output logic              chunk_valid,
   input  logic              chunk_ready,
   input  logic              chunk_ok,
   output logic              chunk_remove,
   output logic [ADDR_W-1:0] chunk_addr,
   output logic [3:0]        chunk_size,
   output logic              done,
   output logic              done_fail,
   output logic [LEN_W:0]    done_count,
   output logic              done_fits
);
   localparam int CNT_W = LEN_W + 1;

   generate
      if (LEN_W < 4)         begin : g_bad_len  $error("LEN_W must be at least 4");  end
      if (ADDR_W < 4)        begin : g_bad_addr $error("ADDR_W must be at least 4"); end
      if (NUM_SLOTS < 1 || NUM_SLOTS >= (1 << CNT_W))
                             begin : g_bad_slot $error("NUM_SLOTS out of range");    end
   endgenerate

   wp_state_e          st_q;
   wp_op_e             op_q;
   logic [ADDR_W-1:0]  addr_q;
   logic [LEN_W-1:0]   rem_q;
   logic [CNT_W-1:0]   cnt_q;
   logic               first_q;
   logic               done_q;
   logic               fail_q;
   logic [CNT_W-1:0]   dcnt_q;

   logic [3:0]         lut_size;
   logic [3:0]         byp_size;
   logic               byp_hit;
   logic [3:0]         size_sel;
   logic               run;
   logic               is_count;
   logic               last;
   logic               xfer;
   logic               advance;
   logic               reject;

   wp_size_lut #(.LEN_W(LEN_W), .WIDE(WIDE)) u_lut (
      .addr_lo (addr_q[2:0]),
      .rem_len (rem_q),
      .size    (lut_size)
   );

   wp_bypass_chk #(.LEN_W(LEN_W), .WIDE(WIDE)) u_byp (
      .addr_lo (addr_q[2:0]),
      .len     (rem_q),
      .hit     (byp_hit),
      .size    (byp_size)
   );

   assign size_sel = (first_q && byp_hit) ? byp_size : lut_size;
   assign run      = (st_q == ST_RUN);
   assign is_count = op_is_count(op_q);
   assign last     = (rem_q == LEN_W'(size_sel));
   assign xfer     = chunk_valid && chunk_ready;
   assign advance  = run && (is_count || (xfer && chunk_ok));
   assign reject   = xfer && !chunk_ok;

   assign req_ready    = !run;
   assign chunk_valid  = run && !is_count;
   assign chunk_remove = (op_q == OP_REMOVE);
   assign chunk_addr   = addr_q;
   assign chunk_size   = size_sel;
   assign done         = done_q;
   assign done_fail    = fail_q;
   assign done_count   = dcnt_q;
   assign done_fits    = (dcnt_q <= CNT_W'(NUM_SLOTS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         op_q    <= OP_COUNT;
         addr_q  <= '0;
         rem_q   <= '0;
         cnt_q   <= '0;
         first_q <= 1'b0;
         done_q  <= 1'b0;
         fail_q  <= 1'b0;
         dcnt_q  <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (req_valid) begin
                  if (req_len == '0) begin
                     done_q <= 1'b1;
                     fail_q <= 1'b0;
                     dcnt_q <= '0;
                  end else begin
                     st_q    <= ST_RUN;
                     op_q    <= wp_op_e'(req_op);
                     addr_q  <= req_addr;
                     rem_q   <= req_len;
                     cnt_q   <= '0;
                     first_q <= 1'b1;
                  end
               end
            end
            ST_RUN: begin
               if (reject) begin
                  st_q   <= ST_IDLE;
                  done_q <= 1'b1;
                  fail_q <= 1'b1;
                  dcnt_q <= cnt_q;
               end else if (advance) begin
                  addr_q  <= addr_q + ADDR_W'(size_sel);
                  rem_q   <= rem_q - LEN_W'(size_sel);
                  cnt_q   <= cnt_q + CNT_W'(1);
                  first_q <= 1'b0;
                  if (last) begin
                     st_q   <= ST_IDLE;
                     done_q <= 1'b1;
                     fail_q <= 1'b0;
                     dcnt_q <= cnt_q + CNT_W'(1);
                  end
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/wp_split_chk.sv
module wp_split_chk #(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 8,
   parameter bit WIDE   = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic [LEN_W-1:0]  req_len,
   input logic              chunk_valid,
   input logic              chunk_ready,
   input logic              chunk_ok,
   input logic              chunk_remove,
   input logic [ADDR_W-1:0] chunk_addr,
   input logic [3:0]        chunk_size,
   input logic              done,
   input logic              done_fail
);
   localparam int MAXB = WIDE ? 8 : 4;

   // R10: a stalled piece keeps its fields
   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      chunk_valid && !chunk_ready |=> chunk_valid && $stable(chunk_addr)
                                      && $stable(chunk_size) && $stable(chunk_remove));

   // R10: busy after taking a nonzero request
   assert_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready && (req_len != '0) |=> !req_ready);

   // R2: legal and naturally aligned piece
   assert_shape_R2: assert property (@(posedge clk) disable iff (!rst_n)
      chunk_valid |-> $onehot0(chunk_size) && (chunk_size != 4'd0)
                      && (chunk_size <= 4'(MAXB))
                      && ((chunk_addr[2:0] & (chunk_size[2:0] - 3'd1)) == 3'd0));

   // R7: a rejection ends the request with failure
   assert_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
      chunk_valid && chunk_ready && !chunk_ok |=> done && done_fail && !chunk_valid);

   // R11: done lasts one cycle unless a new empty request is taken
   assert_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done && !(req_valid && req_ready && (req_len == '0)) |=> !done);
endmodule

bind wp_region_splitter wp_split_chk #(
   .ADDR_W (ADDR_W),
   .LEN_W  (LEN_W),
   .WIDE   (WIDE)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .req_ready    (req_ready),
   .req_len      (req_len),
   .chunk_valid  (chunk_valid),
   .chunk_ready  (chunk_ready),
   .chunk_ok     (chunk_ok),
   .chunk_remove (chunk_remove),
   .chunk_addr   (chunk_addr),
   .chunk_size   (chunk_size),
   .done         (done),
   .done_fail    (done_fail)
);

// File: tb/tb_wp_region_splitter.sv
`timescale 1ns/1ps
module tb_wp_region_splitter;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_op = 2'd0;
   logic [31:0] req_addr = '0;
   logic [7:0]  req_len = '0;
   logic [1:0]  cur_op = 2'd0;
   int          rej_idx = 1000;
   int          cyc = 0;
   int          checks = 0;
   int          fails = 0;

   logic        res_rr   [2];
   logic        res_cv   [2];
   logic        res_dn   [2];
   logic        res_got  [2];
   logic        res_fail [2];
   logic        res_fits [2];
   logic [8:0]  res_cnt  [2];
   int          res_lat  [2];
   int          res_chk  [2];
   int          res_bad  [2];

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic int msz(input longint unsigned a, input int rem, input int mx);
      for (int p = mx; p > 1; p = p / 2)
         if (p <= rem && (a % p) == 0) return p;
      return 1;
   endfunction

   function automatic int nchunks(input longint unsigned a, input int len, input int mx);
      int n = 0;
      while (len > 0) begin
         int s = msz(a, len, mx);
         a = a + s; len = len - s; n++;
      end
      return n;
   endfunction

   for (genvar g = 0; g < 2; g++) begin : gen_inst
      localparam int MX = (g == 1) ? 8 : 4;
      logic        rdy = 1'b0;
      logic        rr, cv, cok, crm, dn, dfail, dfits;
      logic [31:0] ca;
      logic [3:0]  cs;
      logic [8:0]  dcnt;
      logic [31:0] m_addr = '0;
      int          m_rem = 0;
      int          acc = 0;
      int          start = 0;
      int          lat = 0;
      logic        got = 1'b0;
      int          n_chk = 0;
      int          n_bad = 0;

      assign cok = (acc != rej_idx);

      wp_region_splitter #(.ADDR_W(32), .LEN_W(8), .WIDE(g == 1), .NUM_SLOTS(4)) dut (
         .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rr),
         .req_op(req_op), .req_addr(req_addr), .req_len(req_len),
         .chunk_valid(cv), .chunk_ready(rdy), .chunk_ok(cok), .chunk_remove(crm),
         .chunk_addr(ca), .chunk_size(cs), .done(dn), .done_fail(dfail),
         .done_count(dcnt), .done_fits(dfits));

      always @(posedge clk) begin
         rdy <= ($urandom % 4) != 0;
         if (rr && req_valid) begin
            acc <= 0; m_addr <= req_addr; m_rem <= int'(req_len); got <= 1'b0; start <= cyc;
         end else if (cv && rdy) begin
            acc    <= acc + 1;
            m_addr <= m_addr + 32'(msz(m_addr, m_rem, MX));
            m_rem  <= m_rem - msz(m_addr, m_rem, MX);
         end
         if (dn) begin got <= 1'b1; lat <= cyc - start; end
      end

      always @(negedge clk) begin
         if (rst_n) begin
            if (cv && got) begin
               n_chk++; n_bad++;
               $display("FAIL R7 inst%0d piece after end: got valid=1 expected 0", g);
            end
            if (cv && (cur_op == 2'd0 || cur_op == 2'd3)) begin
               n_chk++; n_bad++;
               $display("FAIL R5 inst%0d piece in count mode: got valid=1 expected 0", g);
            end
            if (cv && rdy) begin
               int e;
               e = msz(m_addr, m_rem, MX);
               n_chk++;
               if (m_rem <= 0 || ca != m_addr || int'(cs) != e) begin
                  n_bad++;
                  $display("FAIL R2 R3 R4 inst%0d piece: got addr=%h size=%0d expected addr=%h size=%0d",
                           g, ca, cs, m_addr, e);
               end
               n_chk++;
               if (crm != (cur_op == 2'd2)) begin
                  n_bad++;
                  $display("FAIL R6 inst%0d remove flag: got %0b expected %0b", g, crm, cur_op == 2'd2);
               end
            end
         end
      end

      assign res_rr[g] = rr;     assign res_cv[g] = cv;     assign res_dn[g] = dn;
      assign res_got[g] = got;   assign res_fail[g] = dfail; assign res_fits[g] = dfits;
      assign res_cnt[g] = dcnt;  assign res_lat[g] = lat;
      assign res_chk[g] = n_chk; assign res_bad[g] = n_bad;
   end

   task automatic chk(input bit ok, input string what, input int got_v, input int exp_v);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: got %0d expected %0d", what, got_v, exp_v);
      end
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d",
               checks + res_chk[0] + res_chk[1], fails + res_bad[0] + res_bad[1]);
      $finish;
   endtask

   task automatic run(input logic [1:0] op, input logic [31:0] a, input logic [7:0] l, input int rj);
      bit act;
      int t;
      @(negedge clk);
      cur_op = op; req_op = op; req_addr = a; req_len = l; rej_idx = rj; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      if (l != 0) begin
         chk(res_rr[0] == 1'b0, "R10 narrow busy", int'(res_rr[0]), 0);
         chk(res_rr[1] == 1'b0, "R10 wide busy", int'(res_rr[1]), 0);
      end
      t = 0;
      while (t < 800 && !(res_got[0] && res_got[1])) begin
         @(negedge clk); t++;
      end
      if (!(res_got[0] && res_got[1])) begin
         chk(1'b0, "R11 done never seen", 0, 1);
         return;
      end
      act = (op == 2'd1) || (op == 2'd2);
      for (int g = 0; g < 2; g++) begin
         int mx, n, ecnt;
         bit efail;
         mx = (g == 1) ? 8 : 4;
         n = nchunks(a, int'(l), mx);
         efail = act && (rj < n);
         ecnt = efail ? rj : n;
         chk(int'(res_cnt[g]) == ecnt, act ? "R7 count" : "R5 count", int'(res_cnt[g]), ecnt);
         chk(res_fail[g] == efail, "R7 fail flag", int'(res_fail[g]), int'(efail));
         chk(res_fits[g] == (ecnt <= 4), "R5 fits", int'(res_fits[g]), int'(ecnt <= 4));
         if (!act)
            chk(res_lat[g] == n + 1, "R11 count latency", res_lat[g], n + 1);
         if (l == 0)
            chk(res_cnt[g] == 0 && !res_fail[g], "R9 empty", int'(res_cnt[g]), 0);
         if ((l == 1 || l == 2 || l == 4 || (l == 8 && mx == 8)) && (a % l) == 0 && !efail)
            chk(res_cnt[g] == 1, "R8 bypass single", int'(res_cnt[g]), 1);
      end
   endtask

   initial begin
      void'($urandom(32'd20231));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      for (int g = 0; g < 2; g++) begin
         chk(res_rr[g] == 1'b1, "R1 req_ready", int'(res_rr[g]), 1);
         chk(res_cv[g] == 1'b0, "R1 chunk_valid", int'(res_cv[g]), 0);
         chk(res_dn[g] == 1'b0, "R1 done", int'(res_dn[g]), 0);
      end
      // directed corner cases
      run(2'd0, 32'h1000, 8'd0, 1000);    // R9 empty
      run(2'd1, 32'h1004, 8'd4, 1000);    // R8 aligned
      run(2'd1, 32'h2000, 8'd8, 1000);    // R8 wide only
      run(2'd2, 32'h3002, 8'd2, 1000);    // R6 remove
      run(2'd0, 32'h0001, 8'd7, 1000);    // R3 odd start
      run(2'd3, 32'h0003, 8'd16, 1000);   // R5 over budget
      run(2'd0, 32'h0004, 8'd16, 1000);   // R5 boundary
      run(2'd1, 32'h0005, 8'd13, 0);      // R7 first rejected
      run(2'd1, 32'h0005, 8'd13, 2);      // R7 middle rejected
      run(2'd2, 32'h0001, 8'd5, 2);       // R7 last rejected
      run(2'd1, 32'h00ff, 8'd255, 1000);  // R4 long run
      for (int a = 0; a < 8; a++)
         for (int l = 1; l <= 9; l++)
            run(2'd0, 32'(a), 8'(l), 1000);
      for (int i = 0; i < 250; i++) begin
         logic [1:0] op;
         int rj;
         op = 2'($urandom % 4);
         rj = (($urandom % 3) == 0) ? int'($urandom % 6) : 1000;
         run(op, $urandom, 8'($urandom % 48), rj);
      end
      finish_run();
   end

   initial begin
      wait (cyc >= 150000);
      fails++;
      $display("FAIL watchdog: got cycle %0d expected under 150000", cyc);
      finish_run();
   end
endmodule